// File: doc/BRIEF.md
# Fixed-Window SRAM Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and a 128 KB SRAM. It widens each CPU memory address to the 17 bits the SRAM needs. One 16 KB window of the CPU map, 0x8000 to 0xBFFF, is steered into the upper 64 KB of SRAM. Every other CPU address lands unchanged in the lower 64 KB. The two halves therefore never overlap.

Software picks which of the four upper 16 KB banks appears in the window. It does so with an I/O write to one port, whose number is a parameter. The block keeps the low two data bits of that write in a bank register. The register is the only clocked state. The SRAM address and the banked flag are combinational functions of the CPU address, the memory strobe and the register, so a new address is translated in the same cycle it appears.

All interfaces are plain control and address pins. There is no streamed data path and no back-pressure: the CPU bus sets the pace, and every strobe is sampled on each rising clock edge.

Top module: `bankmap_top`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the bank register to 0. A memory access to 0x8000 after reset therefore produces SRAM address 0x10000.
- R2: At a rising edge where iorq_n=0, wr_n=0 and cpu_addr[7:0] equals the PORT parameter, the bank register loads cpu_data[1:0].
- R3: An I/O write to any port other than PORT leaves the bank register unchanged.
- R4: An I/O read (iorq_n=0, wr_n=1) to PORT leaves the bank register unchanged.
- R5: A memory write (mreq_n=0, wr_n=0, iorq_n=1) whose low address byte equals PORT leaves the bank register unchanged.
- R6: When mreq_n=0 and cpu_addr[15:14]=2'b10, sram_addr[16]=1, sram_addr[15:14] equals the bank register, sram_addr[13:0]=cpu_addr[13:0], and banked=1.
- R7: When mreq_n=0 and cpu_addr[15:14] is not 2'b10, sram_addr={1'b0, cpu_addr} and banked=0. This includes the window edges 0x7FFF and 0xC000.
- R8: When mreq_n=1, sram_addr={1'b0, cpu_addr} and banked=0, even if the address lies in the window.
- R9: A bank value that is loaded takes effect for the first memory access after the capturing edge.
- R10: Data bits cpu_data[7:2] have no effect on the value the bank register loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus, bits 1..0 feed the bank register |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| sram_addr | output | 17 | Translated SRAM address |
| banked | output | 1 | High while a memory cycle falls inside the window |

## Verification
The properties assume that the CPU never asserts mreq_n and iorq_n low together. They also assume that the strobes and the address are stable around each rising edge, so the edge sees one whole bus cycle. The stimulus follows both rules. Every input changes a quarter period after a rising edge, and each bus cycle is either a memory cycle or an I/O cycle, never both. The negative tests for R3, R4 and R5 each vary exactly one qualifier of a register write. The effect of each test is then read back through a memory access into the window.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  // CPU side geometry
  localparam int unsigned CPU_AW   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned PORT_W   = 8;
  // Window geometry: the top WIN_BITS of the CPU address select the window
  localparam int unsigned WIN_BITS = 2;
  localparam logic [WIN_BITS-1:0] WIN_CODE = 2'b10;
  // Derived SRAM geometry: one extra address bit separates banked from flat space
  localparam int unsigned SRAM_AW  = CPU_AW + 1;
  localparam int unsigned BANK_W   = WIN_BITS;
  localparam int unsigned OFFS_W   = CPU_AW - WIN_BITS;

  typedef logic [CPU_AW-1:0]  cpu_addr_t;
  typedef logic [SRAM_AW-1:0] sram_addr_t;
  typedef logic [BANK_W-1:0]  bank_t;
endpackage

// File: rtl/bankmap_port_decode.sv
module bankmap_port_decode
  import bankmap_pkg::*;
#(
  parameter logic [PORT_W-1:0] PORT = 8'h40
) (
  input  logic [PORT_W-1:0] port_addr,
  input  logic              iorq_n,
  input  logic              wr_n,
  output logic              load_en
);
  logic port_hit;
  logic io_write;

  always_comb begin
    port_hit = (port_addr == PORT);
    io_write = ~iorq_n & ~wr_n;
    load_en  = port_hit & io_write;
  end
endmodule

// File: rtl/bankmap_bank_reg.sv
module bankmap_bank_reg
  import bankmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DATA_W-1:0] data_in,
  output bank_t             bank_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
    end else if (load_en) begin
      bank_q <= data_in[BANK_W-1:0];
    end
  end
endmodule

// File: rtl/bankmap_window.sv
module bankmap_window
  import bankmap_pkg::*;
(
  input  cpu_addr_t  cpu_addr,
  input  logic       mreq_n,
  input  bank_t      bank,
  output sram_addr_t sram_addr,
  output logic       in_window
);
  logic hit;

  always_comb begin
    hit       = ~mreq_n & (cpu_addr[CPU_AW-1 -: WIN_BITS] == WIN_CODE);
    in_window = hit;
  end

  // Offset bits inside the window always pass straight through
  assign sram_addr[OFFS_W-1:0] = cpu_addr[OFFS_W-1:0];

  // Each window bit is a 2:1 mux between the CPU bit and the bank bit
  for (genvar i = 0; i < WIN_BITS; i++) begin : g_win_mux
    assign sram_addr[OFFS_W+i] = hit ? bank[i] : cpu_addr[OFFS_W+i];
  end

  // Top SRAM bit separates the banked half from the flat half
  assign sram_addr[SRAM_AW-1] = hit;
endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
  import bankmap_pkg::*;
#(
  parameter logic [PORT_W-1:0] PORT = 8'h40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_data,
  input  logic                mreq_n,
  input  logic                iorq_n,
  input  logic                wr_n,
  output logic [SRAM_AW-1:0]  sram_addr,
  output logic                banked
);
  logic  load_en;
  bank_t bank_q;

  bankmap_port_decode #(.PORT(PORT)) u_dec (
    .port_addr (cpu_addr[PORT_W-1:0]),
    .iorq_n    (iorq_n),
    .wr_n      (wr_n),
    .load_en   (load_en)
  );

  bankmap_bank_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .data_in (cpu_data),
    .bank_q  (bank_q)
  );

  bankmap_window u_win (
    .cpu_addr  (cpu_addr),
    .mreq_n    (mreq_n),
    .bank      (bank_q),
    .sram_addr (sram_addr),
    .in_window (banked)
  );
endmodule

// File: rtl/bankmap_checker.sv
module bankmap_checker #(
  parameter logic [7:0] PORT = 8'h40
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_data,
  input logic        mreq_n,
  input logic        iorq_n,
  input logic        wr_n,
  input logic [16:0] sram_addr,
  input logic        banked,
  input logic [1:0]  bank_q
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: the edge after a reset edge must see an empty bank register
  always @(posedge clk) begin
    if (rst_seen === 1'b1) begin
      p_reset_clear_r1: assert (bank_q == 2'b00);
    end
  end

  // R2
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!iorq_n && !wr_n && cpu_addr[7:0] == PORT) |=> bank_q == $past(cpu_data[1:0]));

  // R3, R4, R5: without a qualified port write the register holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(!iorq_n && !wr_n && cpu_addr[7:0] == PORT) |=> $stable(bank_q));

  // R6
  p_window_r6: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && cpu_addr[15:14] == 2'b10) |->
      (sram_addr == {1'b1, bank_q, cpu_addr[13:0]}) && banked);

  // R7
  p_flat_r7: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && cpu_addr[15:14] != 2'b10) |->
      (sram_addr == {1'b0, cpu_addr}) && !banked);

  // R8
  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    mreq_n |-> (sram_addr == {1'b0, cpu_addr}) && !banked);
endmodule

bind bankmap_top bankmap_checker #(.PORT(PORT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .cpu_data  (cpu_data),
  .mreq_n    (mreq_n),
  .iorq_n    (iorq_n),
  .wr_n      (wr_n),
  .sram_addr (sram_addr),
  .banked    (banked),
  .bank_q    (bank_q)
);

// File: tb/sim_bankmap_top.sv
`timescale 1ns/1ps
module sim_bankmap_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;
  localparam logic [7:0] PORT = 8'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        mreq_n = 1'b1;
  logic        iorq_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [16:0] sram_addr;
  logic        banked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [16:0] sram;
    logic        bnk;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bankmap_top #(.PORT(PORT)) u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .wr_n(wr_n),
    .sram_addr(sram_addr), .banked(banked)
  );

  // Monitor: pops one expectation per falling edge and compares
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (sram_addr !== e.sram || banked !== e.bnk) begin
        errors++;
        $display("FAIL %s: sram_addr=%05h banked=%b expected sram_addr=%05h banked=%b",
                 e.tag, sram_addr, banked, e.sram, e.bnk);
      end
    end
  end

  task automatic idle();
    mreq_n = 1'b1; iorq_n = 1'b1; wr_n = 1'b1;
  endtask

  // Driver: one bus cycle with an expected result pushed to the scoreboard
  task automatic bus(input logic [15:0] a, input logic [7:0] d,
                     input logic mq, input logic io, input logic w,
                     input logic [16:0] exp_s, input logic exp_b, input string tag);
    exp_t e;
    @(posedge clk); #Q;
    cpu_addr = a; cpu_data = d; mreq_n = mq; iorq_n = io; wr_n = w;
    e.sram = exp_s; e.bnk = exp_b; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic mem(input logic [15:0] a, input logic [16:0] exp_s,
                     input logic exp_b, input string tag);
    bus(a, 8'h00, 1'b0, 1'b1, 1'b1, exp_s, exp_b, tag);
  endtask

  // I/O cycle held across one rising edge, no expectation
  task automatic io(input logic [7:0] port, input logic [7:0] d, input logic w);
    @(posedge clk); #Q;
    cpu_addr = {8'h00, port}; cpu_data = d; mreq_n = 1'b1; iorq_n = 1'b0; wr_n = w;
    @(posedge clk); #Q;
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #Q; rst = 1'b0;

    // R1: reset state, bank 0
    mem(16'h8000, 17'h10000, 1'b1, "R1 reset bank");
    // R7: flat space and window edges
    mem(16'h0000, 17'h00000, 1'b0, "R7 low");
    mem(16'h7FFF, 17'h07FFF, 1'b0, "R7 below window");
    mem(16'hC000, 17'h0C000, 1'b0, "R7 above window");
    mem(16'hFFFF, 17'h0FFFF, 1'b0, "R7 top");
    mem(16'h4ABC, 17'h04ABC, 1'b0, "R7 mid");

    // R2 / R6: load bank 2
    io(PORT, 8'h02, 1'b0);
    mem(16'h8000, 17'h18000, 1'b1, "R6 bank2 first");
    mem(16'hBFFF, 17'h1BFFF, 1'b1, "R6 bank2 last");

    // R10: upper data bits ignored, 0xFD loads bank 1
    io(PORT, 8'hFD, 1'b0);
    mem(16'h8123, 17'h14123, 1'b1, "R10 upper bits");

    // R3: other port
    io(PORT + 8'h01, 8'h03, 1'b0);
    mem(16'h8123, 17'h14123, 1'b1, "R3 other port");

    // R4: I/O read of the port
    io(PORT, 8'h03, 1'b1);
    mem(16'h8123, 17'h14123, 1'b1, "R4 io read");

    // R5: memory write whose low byte matches the port
    bus({8'h00, PORT}, 8'h03, 1'b0, 1'b1, 1'b0, {9'h000, PORT}, 1'b0, "R5 mem write cycle");
    mem(16'h8123, 17'h14123, 1'b1, "R5 mem write");

    // R8: no memory request, window address passes flat
    bus(16'h8123, 8'h00, 1'b1, 1'b1, 1'b1, 17'h08123, 1'b0, "R8 no mreq");
    bus(16'h9001, 8'h00, 1'b1, 1'b0, 1'b1, 17'h09001, 1'b0, "R8 io cycle in window");

    // R9: new bank used by the next access
    io(PORT, 8'h03, 1'b0);
    mem(16'hA5A5, 17'h1E5A5, 1'b1, "R9 bank3 next access");

    // R1: reset again clears bank
    @(posedge clk); #Q; idle(); rst = 1'b1;
    repeat (2) @(posedge clk);
    #Q; rst = 1'b0;
    mem(16'h9000, 17'h11000, 1'b1, "R1 second reset");

    @(posedge clk); #Q; idle();
    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule